// File: doc/BRIEF.md
# Interrupt Request Status and Enable Unit

This block collects single-cycle event pulses and alert levels from the internals of a peripheral. It holds each one in a sticky request bit until software removes it. Software reaches two request registers and two enable registers over a small register bus. The bus has an address, write data, a write strobe and combinational read data.

Every write to a request register carries a selector in bit 7. When bit 7 is 1, the write sets each bit written as 1. When bit 7 is 0, the write clears each bit written as 1. Bits written as 0 are left alone in both cases.

The enabled request bits are combined into one active-high interrupt line. That line drives a pad either push-pull or open-drain, and the drive mode is chosen by a bit in an enable register. The main request register comes out of reset with its idle and low-alert bits already set. The idle request is qualified by how a command ended. The receive-done request is qualified by the receive option and the buffer level.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the request register at 04h reads 14h, meaning idle (bit 4) and low-alert (bit 2) are set. Registers 02h, 03h and 05h read 00h, `irq_o` is low, and the pad is released (`pad_oe_o`=0, `pad_o`=0).
- R2: A write to 04h with bit 7 = 1 sets every request bit in 6..0 that is written as 1. Bits written as 0 keep their value. The result is visible on the cycle after the write.
- R3: A write to 04h with bit 7 = 0 clears every request bit in 6..0 that is written as 1. Bits written as 0 keep their value. If an event for a bit arrives in the same cycle as its clear, the bit ends up set.
- R4: Request bits are never cleared by hardware. They stay set after the event or the alert level goes away. Bit 7 of 04h and of 05h always reads 0.
- R5: A pulse on `tx_done_i` sets bit 6, a pulse on `err_i` sets bit 1, and a pulse on `timer_i` sets bit 0 of 04h.
- R6: A rising edge of `hi_alert_i` sets bit 3 and a rising edge of `lo_alert_i` sets bit 2. An alert level that stays high does not set the bit again after software has cleared it.
- R7: Bit 4 (idle) is set by `cmd_end_i`, which marks a command that finished by itself. It is also set by `cmd_start_i` with an unknown code; with the default parameters, codes 8..15 are unknown. `cmd_start_i` with code 0, the software Idle command, does not set it.
- R8: `rx_end_i` sets bit 5 when `rx_noerr_i` = 0. When `rx_noerr_i` = 1 it sets bit 5 only if `fifo_nonempty_i` = 1.
- R9: Register 02h holds per-bit enables for the bits 6..0 of 04h, and its bit 7 reads 0. Register 03h holds the drive mode in bit 7 (1 = push-pull, 0 = open-drain), the auxiliary-active enable in bit 4 and the checksum enable in bit 2. The other bits of 03h read 0 and ignore writes, and unmapped addresses read 0.
- R10: Register 05h is an auxiliary request register with the same set/clear write format. `aux_act_i` sets bit 4 and `crc_i` sets bit 2, and all other bits read 0.
- R11: `irq_o` is high when any request bit is set together with its enable bit. In push-pull mode `pad_oe_o`=1 and `pad_o`=`irq_o`. In open-drain mode `pad_o`=0 and `pad_oe_o`=`irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| tx_done_i | input | 1 | Transmit done event pulse |
| rx_end_i | input | 1 | End of valid receive stream pulse |
| rx_noerr_i | input | 1 | Receive option: flag only when data is buffered |
| fifo_nonempty_i | input | 1 | Receive buffer holds data |
| cmd_start_i | input | 1 | Command start pulse |
| cmd_code_i | input | CMD_W | Code of the command being started |
| cmd_end_i | input | 1 | Command finished by itself pulse |
| hi_alert_i | input | 1 | Live high-alert level |
| lo_alert_i | input | 1 | Live low-alert level |
| err_i | input | 1 | Error event pulse |
| timer_i | input | 1 | Timer event pulse |
| aux_act_i | input | 1 | Auxiliary input active event pulse |
| crc_i | input | 1 | Checksum done event pulse |
| irq_o | output | 1 | Combined interrupt, active high |
| pad_o | output | 1 | Pad drive value |
| pad_oe_o | output | 1 | Pad output enable |

## Verification
Set and clear writes are tried with masks that mix ones and zeros over bits that are already set and bits that are already clear. This separates a masked update from a plain overwrite and from a flip. Clears are also made to collide with events on the same bit and on other bits, which shows that the event takes priority only for its own bit. The alert inputs are held high across a clear, which separates edge capture from level capture. Command starts are issued with code 0, with a known code and with an unknown code, and receive ends are issued under every combination of the receive option and the buffer level. The interrupt pad is observed with each enable alone and in both drive modes.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int REG_W   = 8;
  localparam int SEL_BIT = 7;

  localparam logic [7:0] ADDR_COMM_EN  = 8'h02;
  localparam logic [7:0] ADDR_DIV_EN   = 8'h03;
  localparam logic [7:0] ADDR_COMM_REQ = 8'h04;
  localparam logic [7:0] ADDR_DIV_REQ  = 8'h05;

  // main request bit positions
  localparam int B_TX   = 6;
  localparam int B_RX   = 5;
  localparam int B_IDLE = 4;
  localparam int B_HI   = 3;
  localparam int B_LO   = 2;
  localparam int B_ERR  = 1;
  localparam int B_TMR  = 0;

  // auxiliary / drive bit positions
  localparam int B_PP   = 7;
  localparam int B_AUX  = 4;
  localparam int B_CRC  = 2;

  localparam logic [REG_W-1:0] COMM_MASK    = 8'h7F;
  localparam logic [REG_W-1:0] COMM_RST     = 8'h14;
  localparam logic [REG_W-1:0] DIV_EN_MASK  = 8'h94;
  localparam logic [REG_W-1:0] DIV_REQ_MASK = 8'h14;

  typedef struct packed {
    logic             wr;
    logic             set;
    logic [REG_W-1:0] mask;
  } req_wr_t;
endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank
  import irq_status_pkg::*;
#(
  parameter int               W     = REG_W,
  parameter logic [W-1:0]     VALID = '1,
  parameter logic [W-1:0]     RST   = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  req_wr_t      wr_i,
  input  logic [W-1:0] evt_i,
  output logic [W-1:0] req_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (VALID[i]) begin : g_flop
      logic q;
      logic clr, st;
      assign st  = wr_i.wr &  wr_i.set & wr_i.mask[i];
      assign clr = wr_i.wr & ~wr_i.set & wr_i.mask[i];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= RST[i];
        else         q <= evt_i[i] | st | (q & ~clr);  // event beats clear
      end
      assign req_o[i] = q;
    end else begin : g_tie
      assign req_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_evt_decode.sv
module irq_evt_decode
  import irq_status_pkg::*;
#(
  parameter int                 CMD_W          = 4,
  parameter int                 CMD_N          = 2 ** CMD_W,
  parameter logic [CMD_N-1:0]   KNOWN_CMD_MASK = {{(CMD_N/2){1'b0}}, {(CMD_N/2){1'b1}}}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_done_i,
  input  logic             rx_end_i,
  input  logic             rx_noerr_i,
  input  logic             fifo_nonempty_i,
  input  logic             cmd_start_i,
  input  logic [CMD_W-1:0] cmd_code_i,
  input  logic             cmd_end_i,
  input  logic             hi_alert_i,
  input  logic             lo_alert_i,
  input  logic             err_i,
  input  logic             timer_i,
  output logic [REG_W-1:0] evt_o
);
  logic hi_q, lo_q;
  logic cmd_unknown;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= hi_alert_i;
      lo_q <= lo_alert_i;
    end
  end

  assign cmd_unknown = cmd_start_i & ~KNOWN_CMD_MASK[cmd_code_i];

  always_comb begin
    evt_o         = '0;
    evt_o[B_TX]   = tx_done_i;
    evt_o[B_RX]   = rx_end_i & (~rx_noerr_i | fifo_nonempty_i);
    evt_o[B_IDLE] = cmd_end_i | cmd_unknown;
    evt_o[B_HI]   = hi_alert_i & ~hi_q;
    evt_o[B_LO]   = lo_alert_i & ~lo_q;
    evt_o[B_ERR]  = err_i;
    evt_o[B_TMR]  = timer_i;
  end
endmodule

// File: rtl/irq_pad_ctrl.sv
module irq_pad_ctrl
  import irq_status_pkg::*;
(
  input  logic [REG_W-1:0] comm_req_i,
  input  logic [REG_W-1:0] comm_en_i,
  input  logic [REG_W-1:0] div_req_i,
  input  logic [REG_W-1:0] div_en_i,
  output logic             irq_o,
  output logic             pad_o,
  output logic             pad_oe_o
);
  logic push_pull;
  assign push_pull = div_en_i[B_PP];
  assign irq_o     = |(comm_req_i & comm_en_i) | |(div_req_i & div_en_i & DIV_REQ_MASK);
  // open-drain: pull low while asserted, float otherwise
  assign pad_o     = push_pull ? irq_o : 1'b0;
  assign pad_oe_o  = push_pull ? 1'b1  : irq_o;
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CMD_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              tx_done_i,
  input  logic              rx_end_i,
  input  logic              rx_noerr_i,
  input  logic              fifo_nonempty_i,
  input  logic              cmd_start_i,
  input  logic [CMD_W-1:0]  cmd_code_i,
  input  logic              cmd_end_i,
  input  logic              hi_alert_i,
  input  logic              lo_alert_i,
  input  logic              err_i,
  input  logic              timer_i,
  input  logic              aux_act_i,
  input  logic              crc_i,
  output logic              irq_o,
  output logic              pad_o,
  output logic              pad_oe_o
);
  logic [REG_W-1:0] comm_en_q, div_en_q;
  logic [REG_W-1:0] comm_req, div_req;
  logic [REG_W-1:0] comm_evt, div_evt;
  req_wr_t          comm_wr, div_wr;
  logic             hit_cen, hit_den, hit_creq, hit_dreq;

  assign hit_cen  = addr_i == ADDR_W'(ADDR_COMM_EN);
  assign hit_den  = addr_i == ADDR_W'(ADDR_DIV_EN);
  assign hit_creq = addr_i == ADDR_W'(ADDR_COMM_REQ);
  assign hit_dreq = addr_i == ADDR_W'(ADDR_DIV_REQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      comm_en_q <= '0;
      div_en_q  <= '0;
    end else if (we_i) begin
      if (hit_cen) comm_en_q <= wdata_i & COMM_MASK;
      if (hit_den) div_en_q  <= wdata_i & DIV_EN_MASK;
    end
  end

  assign comm_wr = '{wr: we_i & hit_creq, set: wdata_i[SEL_BIT], mask: wdata_i & COMM_MASK};
  assign div_wr  = '{wr: we_i & hit_dreq, set: wdata_i[SEL_BIT], mask: wdata_i & DIV_REQ_MASK};

  irq_evt_decode #(.CMD_W(CMD_W)) u_evt (
    .clk_i, .rst_ni, .tx_done_i, .rx_end_i, .rx_noerr_i, .fifo_nonempty_i,
    .cmd_start_i, .cmd_code_i, .cmd_end_i, .hi_alert_i, .lo_alert_i,
    .err_i, .timer_i, .evt_o(comm_evt)
  );

  always_comb begin
    div_evt        = '0;
    div_evt[B_AUX] = aux_act_i;
    div_evt[B_CRC] = crc_i;
  end

  irq_req_bank #(.W(REG_W), .VALID(COMM_MASK), .RST(COMM_RST)) u_comm_bank (
    .clk_i, .rst_ni, .wr_i(comm_wr), .evt_i(comm_evt), .req_o(comm_req)
  );

  irq_req_bank #(.W(REG_W), .VALID(DIV_REQ_MASK), .RST('0)) u_div_bank (
    .clk_i, .rst_ni, .wr_i(div_wr), .evt_i(div_evt), .req_o(div_req)
  );

  irq_pad_ctrl u_pad (
    .comm_req_i(comm_req), .comm_en_i(comm_en_q), .div_req_i(div_req),
    .div_en_i(div_en_q), .irq_o, .pad_o, .pad_oe_o
  );

  always_comb begin
    rdata_o = '0;
    if (hit_cen)  rdata_o = comm_en_q;
    if (hit_den)  rdata_o = div_en_q;
    if (hit_creq) rdata_o = comm_req;
    if (hit_dreq) rdata_o = div_req;
  end
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_status_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CMD_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [REG_W-1:0]  wdata_i,
  input logic [REG_W-1:0]  rdata_o,
  input logic              tx_done_i,
  input logic              cmd_start_i,
  input logic [CMD_W-1:0]  cmd_code_i,
  input logic              cmd_end_i,
  input logic              pad_o,
  input logic              pad_oe_o,
  input logic [REG_W-1:0]  comm_req,
  input logic [REG_W-1:0]  div_en
);
  logic wr_req;
  assign wr_req = we_i && (addr_i == ADDR_W'(ADDR_COMM_REQ));

  AST_SET_MARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && wdata_i[SEL_BIT]) |=> ((comm_req[6:0] & $past(wdata_i[6:0])) == $past(wdata_i[6:0]))); // R2

  AST_CLEAR_MARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && !wdata_i[SEL_BIT] && wdata_i[B_TX] && !tx_done_i) |=> !comm_req[B_TX]); // R3

  AST_NO_AUTO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_req && !wdata_i[SEL_BIT]) |=> ((comm_req & $past(comm_req)) == $past(comm_req))); // R4

  AST_SEL_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(ADDR_COMM_REQ)) |-> !rdata_o[SEL_BIT]); // R4

  AST_TX_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i |=> comm_req[B_TX]); // R5

  AST_SW_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_start_i && cmd_code_i == '0 && !cmd_end_i && !comm_req[B_IDLE] && !wr_req)
    |=> !comm_req[B_IDLE]); // R7

  AST_OD_NEVER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_en[B_PP] |-> !(pad_oe_o && pad_o)); // R11

  AST_PP_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_en[B_PP] |-> pad_oe_o); // R11
endmodule

bind irq_status_unit irq_status_chk #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .tx_done_i(tx_done_i), .cmd_start_i(cmd_start_i),
  .cmd_code_i(cmd_code_i), .cmd_end_i(cmd_end_i), .pad_o(pad_o), .pad_oe_o(pad_oe_o),
  .comm_req(comm_req), .div_en(div_en_q)
);

// File: tb/irq_status_unit_bench.sv
`timescale 1ns/1ps
module irq_status_unit_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we_i = 1'b0;
  logic [7:0] addr_i = 8'h00;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic tx_done_i = 0, rx_end_i = 0, rx_noerr_i = 0, fifo_nonempty_i = 0;
  logic cmd_start_i = 0, cmd_end_i = 0, hi_alert_i = 0, lo_alert_i = 0;
  logic err_i = 0, timer_i = 0, aux_act_i = 0, crc_i = 0;
  logic [3:0] cmd_code_i = 4'h0;
  logic irq_o, pad_o, pad_oe_o;

  int total = 0, fails = 0, cycles = 0;
  string cur_req = "R1";

  // reference state
  int m_comm, m_cen, m_den, m_dreq;
  bit hp, lp;

  always #5 clk = ~clk;

  irq_status_unit u_irq_status_unit (
    .clk_i(clk), .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .tx_done_i, .rx_end_i, .rx_noerr_i, .fifo_nonempty_i,
    .cmd_start_i, .cmd_code_i, .cmd_end_i, .hi_alert_i, .lo_alert_i,
    .err_i, .timer_i, .aux_act_i, .crc_i, .irq_o, .pad_o, .pad_oe_o
  );

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_comm = 'h14; m_cen = 0; m_den = 0; m_dreq = 0; hp = 0; lp = 0;
    end else begin
      int ev, dv;
      ev = 0;
      if (tx_done_i) ev += 64;
      if (rx_end_i && (!rx_noerr_i || fifo_nonempty_i)) ev += 32;
      if (cmd_end_i || (cmd_start_i && cmd_code_i >= 8)) ev += 16;
      if (hi_alert_i && !hp) ev += 8;
      if (lo_alert_i && !lp) ev += 4;
      if (err_i) ev += 2;
      if (timer_i) ev += 1;
      dv = (aux_act_i ? 16 : 0) + (crc_i ? 4 : 0);
      if (we_i) begin
        case (addr_i)
          8'h02: m_cen = wdata_i & 'h7F;
          8'h03: m_den = wdata_i & 'h94;
          8'h04: m_comm = wdata_i[7] ? (m_comm | (wdata_i & 'h7F)) : (m_comm & ~int'(wdata_i) & 'h7F);
          8'h05: m_dreq = wdata_i[7] ? (m_dreq | (wdata_i & 'h14)) : (m_dreq & ~int'(wdata_i) & 'h14);
          default: ;
        endcase
      end
      m_comm = m_comm | ev;
      m_dreq = m_dreq | dv;
      hp = hi_alert_i;
      lp = lo_alert_i;
    end
  end

  function automatic int model_read(logic [7:0] a);
    case (a)
      8'h02: return m_cen;
      8'h03: return m_den;
      8'h04: return m_comm;
      8'h05: return m_dreq;
      default: return 0;
    endcase
  endfunction

  task automatic check(string what, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    bit irq_e;
    irq_e = ((m_comm & m_cen) != 0) || ((m_dreq & m_den & 'h14) != 0);
    check("rdata", int'(rdata_o), model_read(addr_i));
    check("irq", int'(irq_o), int'(irq_e));
    check("pad_oe", int'(pad_oe_o), m_den[7] ? 1 : int'(irq_e));
    check("pad", int'(pad_o), m_den[7] ? int'(irq_e) : 0);
  endtask

  task automatic cyc();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    we_i = 1; addr_i = a; wdata_i = d;
    cyc();
    we_i = 0;
  endtask

  task automatic rd(logic [7:0] a);
    addr_i = a;
    cyc();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_ni = 1;
    // R1 reset values
    cur_req = "R1";
    rd(8'h04); check("R1 req reset", int'(rdata_o), 'h14);
    rd(8'h02); rd(8'h03); rd(8'h05);
    check("R1 irq low", int'(irq_o), 0);
    check("R1 pad released", int'(pad_oe_o), 0);

    // R2 masked set
    cur_req = "R2";
    wr(8'h04, 8'hC1); rd(8'h04);
    check("R2 set 6,0", int'(rdata_o), 'h55);
    wr(8'h04, 8'h80); rd(8'h04);

    // R3 masked clear, collision
    cur_req = "R3";
    wr(8'h04, 8'h05); rd(8'h04);
    check("R3 clear 2,0", int'(rdata_o), 'h50);
    tx_done_i = 1; timer_i = 1;
    wr(8'h04, 8'h41);
    tx_done_i = 0; timer_i = 0;
    rd(8'h04);
    check("R3 event beats clear", int'(rdata_o), 'h51);
    wr(8'h04, 8'h7F); rd(8'h04);
    check("R3 clear all", int'(rdata_o), 0);

    // R5 event pulses, R4 stickiness
    cur_req = "R5";
    err_i = 1; cyc(); err_i = 0;
    timer_i = 1; cyc(); timer_i = 0;
    tx_done_i = 1; cyc(); tx_done_i = 0;
    repeat (3) cyc();
    cur_req = "R4";
    check("R4 sticky after pulses", int'(rdata_o), 'h43);
    check("R4 bit7 reads 0", int'(rdata_o[7]), 0);
    wr(8'h04, 8'h43);

    // R6 alerts, edge captured
    cur_req = "R6";
    hi_alert_i = 1; cyc(); cyc();
    check("R6 hi set", int'(rdata_o), 'h08);
    wr(8'h04, 8'h08); repeat (3) cyc();
    check("R6 held level no reset", int'(rdata_o), 0);
    hi_alert_i = 0; lo_alert_i = 1; cyc(); cyc();
    check("R6 lo set", int'(rdata_o), 'h04);
    lo_alert_i = 0; repeat (2) cyc();
    check("R6 stays after drop", int'(rdata_o), 'h04);
    wr(8'h04, 8'h04);

    // R7 idle qualification
    cur_req = "R7";
    cmd_start_i = 1; cmd_code_i = 4'h0; cyc(); cmd_start_i = 0; cyc();
    check("R7 sw idle quiet", int'(rdata_o), 0);
    cmd_start_i = 1; cmd_code_i = 4'h3; cyc(); cmd_start_i = 0; cyc();
    check("R7 known cmd quiet", int'(rdata_o), 0);
    cmd_end_i = 1; cyc(); cmd_end_i = 0; cyc();
    check("R7 self end", int'(rdata_o), 'h10);
    wr(8'h04, 8'h10);
    cmd_start_i = 1; cmd_code_i = 4'h9; cyc(); cmd_start_i = 0; cyc();
    check("R7 unknown cmd", int'(rdata_o), 'h10);
    wr(8'h04, 8'h10);

    // R8 receive qualification
    cur_req = "R8";
    for (int k = 0; k < 4; k++) begin
      rx_noerr_i = k[1]; fifo_nonempty_i = k[0];
      rx_end_i = 1; cyc(); rx_end_i = 0; cyc();
      check("R8 rx flag", int'(rdata_o[5]), (k == 2) ? 0 : 1);
      wr(8'h04, 8'h20);
    end
    rx_noerr_i = 0; fifo_nonempty_i = 0;

    // R9 enable registers
    cur_req = "R9";
    wr(8'h03, 8'hFF); rd(8'h03);
    check("R9 div en mask", int'(rdata_o), 'h94);
    wr(8'h02, 8'hFF); rd(8'h02);
    check("R9 comm en mask", int'(rdata_o), 'h7F);
    rd(8'h10);
    check("R9 unmapped", int'(rdata_o), 0);
    wr(8'h02, 8'h00); wr(8'h03, 8'h00);

    // R10 auxiliary requests
    cur_req = "R10";
    addr_i = 8'h05;
    aux_act_i = 1; cyc(); aux_act_i = 0; cyc();
    check("R10 aux set", int'(rdata_o), 'h10);
    crc_i = 1; cyc(); crc_i = 0; cyc();
    check("R10 crc set", int'(rdata_o), 'h14);
    aux_act_i = 1;
    wr(8'h05, 8'h14);
    aux_act_i = 0; rd(8'h05);
    check("R10 clear with collision", int'(rdata_o), 'h10);
    wr(8'h05, 8'hFF); rd(8'h05);
    check("R10 set form", int'(rdata_o), 'h14);
    wr(8'h05, 8'h14);

    // R11 interrupt line and pad modes
    cur_req = "R11";
    err_i = 1; cyc(); err_i = 0; cyc();
    check("R11 disabled no irq", int'(irq_o), 0);
    wr(8'h02, 8'h02); cyc();
    check("R11 od asserted oe", int'(pad_oe_o), 1);
    check("R11 od low", int'(pad_o), 0);
    wr(8'h03, 8'h80); cyc();
    check("R11 pp high", int'(pad_o), 1);
    wr(8'h04, 8'h02); cyc();
    check("R11 pp low driven", int'(pad_oe_o), 1);
    check("R11 pp irq off", int'(pad_o), 0);
    wr(8'h03, 8'h04); crc_i = 1; cyc(); crc_i = 0; cyc();
    check("R11 crc enable irq", int'(irq_o), 1);
    wr(8'h03, 8'h10); cyc();
    check("R11 aux enable only", int'(irq_o), 0);
    aux_act_i = 1; cyc(); aux_act_i = 0; cyc();
    check("R11 aux irq", int'(irq_o), 1);
    wr(8'h05, 8'h14); cyc();
    check("R11 released", int'(pad_oe_o), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule